// File: doc/BRIEF.md
# Hardware Standby Sequencer

This block sits at chip level and steers a microcontroller between normal operation, a pin-controlled low-power standby, and the reset recovery that follows it. Two asynchronous active-low pins drive it: a standby request and a reset request. A RAM-enable control bit and the mode-select inputs are also sampled. From these it derives the global functional reset, the I/O tristate enable, the oscillator enable, a flag saying whether on-chip RAM contents can be trusted after standby, a one-cycle strobe that starts reset exception handling, and a run indication.

Standby is entered only through the pin, from any state. Leaving it takes a two-pin sequence. The standby pin must rise while reset is still held low. Reset must then stay low for an oscillator settling time before it is released. The block also checks three timing rules:
- the reset-to-standby lead needed for RAM retention;
- early release of reset before the oscillator has settled;
- mode-pin changes made during standby.

Violations of the last two set sticky flags. A failed retention lead clears the retention flag.

Top module: `hw_standby_seq`

## Requirements
- R1: While `por_n` is low and right after it is released, the block is in the reset state: `func_rst`=1, `osc_en`=1, `io_hiz`=1, `ret_valid`=0, `run`=0, `rst_exc_stb`=0, `stab_viol`=0, `mode_viol`=0.
- R2: `stby_n_pin` low forces standby from the reset, exception or run state within 3 clock cycles, because both pins pass through two-flop synchronizers. In standby `osc_en`=0, `io_hiz`=1, `func_rst`=1 and `run`=0.
- R3: Standby is left only on a rising edge of the synchronized `stby_n_pin` while the synchronized `res_n_pin` is low. The block then enters the reset state with `osc_en`=1. If the standby pin rises while reset is high, the block stays in standby, and a later fall of reset alone does not release it.
- R4: When `res_n_pin` rises after it has been low for at least `STAB_CYCLES` cycles in the reset state since the oscillator started, the block issues `rst_exc_stb` for exactly one cycle and then holds `run`=1, with `func_rst`=0 and `io_hiz`=0.
- R5: If reset rises before the settling count completes, `stab_viol` is set and stays set until power-on reset, and the block stays in reset. The settling count restarts from zero on the next reset low.
- R6: At standby entry with `ram_en`=1, `ret_valid` becomes 1 only if synchronized reset was low for at least `RES_LEAD` consecutive cycles before the standby pin fell; otherwise it becomes 0. With `ram_en`=0 it becomes 1. The value holds until the next standby entry.
- R7: Reset may rise in the same cycle as the standby pin falls, or any time after. The block stays in standby, and the retention result follows R6.
- R8: `mode_sel` is captured at standby entry. Any difference from the captured value while in standby sets the sticky `mode_viol`. An unchanged value leaves it at 0.
- R9: After the oscillator has settled once, a reset pulse taken from the run state returns to run through one `rst_exc_stb` pulse as soon as reset rises, without setting `stab_viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stby_n_pin | input | 1 | Standby request pin, active low, asynchronous |
| res_n_pin | input | 1 | Reset request pin, active low, asynchronous |
| ram_en | input | 1 | RAM-enable control bit sampled at standby entry |
| mode_sel | input | MODE_W | Mode-select inputs, expected static in standby |
| func_rst | output | 1 | Global functional reset, active high |
| io_hiz | output | 1 | I/O tristate enable |
| osc_en | output | 1 | Oscillator enable |
| ret_valid | output | 1 | RAM retention valid |
| rst_exc_stb | output | 1 | One-cycle reset exception strobe |
| run | output | 1 | Program run indication |
| stab_viol | output | 1 | Sticky early-reset-release flag |
| mode_viol | output | 1 | Sticky mode-change-in-standby flag |

## Verification
The bench builds the block with `STAB_CYCLES`=40 in place of the multi-million-cycle default. This brings full settling runs, early releases and the restart of the count after a violation within a few hundred cycles. `RES_LEAD` keeps its value of 10, so the bench can probe leads of 9, 10 and 12 cycles and hit the exact retention boundary. `MODE_W`=3 leaves room for several distinct mode values.

// File: rtl/hw_standby_seq.sv
module hw_standby_seq #(
  parameter int STAB_CYCLES = 2000000,
  parameter int RES_LEAD    = 10,
  parameter int MODE_W      = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              stby_n_pin,
  input  logic              res_n_pin,
  input  logic              ram_en,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              func_rst,
  output logic              io_hiz,
  output logic              osc_en,
  output logic              ret_valid,
  output logic              rst_exc_stb,
  output logic              run,
  output logic              stab_viol,
  output logic              mode_viol
);

  localparam int SW = $clog2(STAB_CYCLES + 1);
  localparam int LW = $clog2(RES_LEAD + 1);
  localparam logic [SW-1:0] STAB_MAX = SW'(STAB_CYCLES);
  localparam logic [LW-1:0] LEAD_MAX = LW'(RES_LEAD);

  typedef enum logic [1:0] {S_RST, S_SBY, S_EXC, S_RUN} st_t;

  st_t st, nx;
  logic [1:0] stby_sync, res_sync;
  logic stby_s, res_s, stby_q, stby_rise;
  logic [SW-1:0] stab_cnt;
  logic [LW-1:0] res_lo;
  logic osc_ok, entering;
  logic [MODE_W-1:0] mode_cap;

  assign stby_s    = stby_sync[1];
  assign res_s     = res_sync[1];
  assign stby_rise = !stby_q && stby_s;
  assign entering  = (nx == S_SBY) && (st != S_SBY);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stby_sync <= 2'b11;
      res_sync  <= 2'b00;
      stby_q    <= 1'b1;
    end else begin
      stby_sync <= {stby_sync[0], stby_n_pin};
      res_sync  <= {res_sync[0], res_n_pin};
      stby_q    <= stby_s;
    end
  end

  always_comb begin
    nx = st;
    case (st)
      S_SBY: if (stby_rise && !res_s) nx = S_RST;
      S_RST: if (res_s && (osc_ok || stab_cnt == STAB_MAX)) nx = S_EXC;
      S_EXC: nx = res_s ? S_RUN : S_RST;
      S_RUN: if (!res_s) nx = S_RST;
      default: nx = S_RST;
    endcase
    if (!stby_s && st != S_SBY) nx = S_SBY;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st        <= S_RST;
      stab_cnt  <= '0;
      osc_ok    <= 1'b0;
      stab_viol <= 1'b0;
    end else begin
      st <= nx;
      if (nx == S_RST && st != S_RST)
        stab_cnt <= '0;
      else if (st == S_RST && res_s)
        stab_cnt <= '0;
      else if (st == S_RST && !osc_ok && stab_cnt != STAB_MAX)
        stab_cnt <= stab_cnt + 1'b1;

      if (nx == S_SBY)
        osc_ok <= 1'b0;
      else if (st == S_RST && stab_cnt == STAB_MAX)
        osc_ok <= 1'b1;

      if (st == S_RST && res_s && !osc_ok && stab_cnt != STAB_MAX)
        stab_viol <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      res_lo    <= '0;
      ret_valid <= 1'b0;
      mode_cap  <= '0;
      mode_viol <= 1'b0;
    end else begin
      if (res_s)                  res_lo <= '0;
      else if (res_lo != LEAD_MAX) res_lo <= res_lo + 1'b1;

      if (entering) begin
        ret_valid <= !ram_en || (res_lo == LEAD_MAX);
        mode_cap  <= mode_sel;
      end

      if (st == S_SBY && mode_sel != mode_cap)
        mode_viol <= 1'b1;
    end
  end

  assign func_rst    = (st == S_RST) || (st == S_SBY);
  assign io_hiz      = (st == S_RST) || (st == S_SBY);
  assign osc_en      = (st != S_SBY);
  assign rst_exc_stb = (st == S_EXC);
  assign run         = (st == S_RUN);

  // R2
  enter_sby_chk: assert property (@(posedge clk) disable iff (!por_n)
    (stby_q && !stby_s) |=> (!osc_en && io_hiz && func_rst && !run));

  // R2
  sby_outputs_chk: assert property (@(posedge clk) disable iff (!por_n)
    !osc_en |-> (io_hiz && func_rst && !run && !rst_exc_stb));

  // R3
  exit_to_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_en && stby_rise && !res_s) |=> (osc_en && func_rst && !run));

  // R4
  stb_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_exc_stb |=> !rst_exc_stb);

  // R4
  run_outputs_chk: assert property (@(posedge clk) disable iff (!por_n)
    run |-> (osc_en && !io_hiz && !func_rst));

  // R5
  stab_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    stab_viol |=> stab_viol);

  // R8
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    mode_viol |=> mode_viol);

endmodule

// File: tb/tb_hw_standby_seq.sv
module tb_hw_standby_seq;
  localparam int STAB = 40;
  localparam int LEAD = 10;

  logic clk = 1'b0;
  logic por_n, stby_n, res_n, ram_en;
  logic [2:0] mode_sel;
  logic func_rst, io_hiz, osc_en, ret_valid, rst_exc_stb, run, stab_viol, mode_viol;
  int checks = 0, fails = 0, stb_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hw_standby_seq #(.STAB_CYCLES(STAB), .RES_LEAD(LEAD), .MODE_W(3)) dut (
    .clk(clk), .por_n(por_n), .stby_n_pin(stby_n), .res_n_pin(res_n),
    .ram_en(ram_en), .mode_sel(mode_sel), .func_rst(func_rst), .io_hiz(io_hiz),
    .osc_en(osc_en), .ret_valid(ret_valid), .rst_exc_stb(rst_exc_stb), .run(run),
    .stab_viol(stab_viol), .mode_viol(mode_viol));

  always @(negedge clk) if (rst_exc_stb === 1'b1) stb_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic leave_standby_to_run();
    int s0;
    res_n = 1'b0; cyc(3);
    stby_n = 1'b1; cyc(STAB + 10);
    s0 = stb_cnt;
    res_n = 1'b1; cyc(6);
    chk("R4 run after settle", run, 1);
    chk("R4 one strobe", stb_cnt - s0, 1);
  endtask

  task automatic t_por();
    chk("R1 func_rst", func_rst, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 io_hiz", io_hiz, 1);
    chk("R1 ret_valid", ret_valid, 0);
    chk("R1 run", run, 0);
    chk("R1 flags", {stab_viol, mode_viol, rst_exc_stb}, 0);
    por_n = 1'b1; cyc(3);
    chk("R1 after release", {func_rst, osc_en, io_hiz, ret_valid, run}, 5'b11100);
  endtask

  task automatic t_bring_up();
    int s0;
    cyc(STAB + 10);
    s0 = stb_cnt;
    res_n = 1'b1; cyc(6);
    chk("R4 run", run, 1);
    chk("R4 io released", {func_rst, io_hiz}, 0);
    chk("R4 strobe count", stb_cnt - s0, 1);
    chk("R4 no violation", stab_viol, 0);
  endtask

  task automatic t_warm();
    int s0;
    res_n = 1'b0; cyc(5);
    chk("R9 in reset", {func_rst, run, osc_en}, 3'b101);
    s0 = stb_cnt;
    res_n = 1'b1; cyc(6);
    chk("R9 back to run", run, 1);
    chk("R9 strobe", stb_cnt - s0, 1);
    chk("R9 no stab_viol", stab_viol, 0);
  endtask

  task automatic t_enter_from_run();
    stby_n = 1'b0; cyc(4);
    chk("R2 osc off", osc_en, 0);
    chk("R2 held", {io_hiz, func_rst, run}, 3'b110);
  endtask

  task automatic t_exit_wrong();
    stby_n = 1'b1; cyc(5);
    chk("R3 stby rise with res high stays", osc_en, 0);
    res_n = 1'b0; cyc(5);
    chk("R3 res fall alone stays", osc_en, 0);
    stby_n = 1'b0; cyc(3);
    stby_n = 1'b1; cyc(5);
    chk("R3 exit to reset osc", osc_en, 1);
    chk("R3 exit reset held", {func_rst, run}, 2'b10);
  endtask

  task automatic t_stab_short();
    cyc(5);
    res_n = 1'b1; cyc(4);
    chk("R5 violation flagged", stab_viol, 1);
    chk("R5 stays reset", {func_rst, run}, 2'b10);
    res_n = 1'b0; cyc(35);
    res_n = 1'b1; cyc(4);
    chk("R5 count restarted", run, 0);
    chk("R5 sticky", stab_viol, 1);
    res_n = 1'b0; cyc(STAB + 10);
    res_n = 1'b1; cyc(6);
    chk("R5 full settle runs", run, 1);
  endtask

  task automatic t_ret(input int lead, input bit ram, input int exp);
    ram_en = ram;
    res_n = 1'b0; cyc(lead);
    stby_n = 1'b0; cyc(5);
    chk($sformatf("R6 ret lead=%0d ram=%0d", lead, ram), ret_valid, exp);
    chk("R2 entry from reset", osc_en, 0);
    leave_standby_to_run();
    chk("R6 ret held", ret_valid, exp);
  endtask

  task automatic t_zero_hold();
    ram_en = 1'b1;
    res_n = 1'b0; cyc(12);
    stby_n = 1'b0; res_n = 1'b1; cyc(5);
    chk("R7 standby with res high", {osc_en, run}, 0);
    chk("R7 retention", ret_valid, 1);
    leave_standby_to_run();
  endtask

  task automatic t_mode();
    mode_sel = 3'd5;
    ram_en = 1'b0;
    res_n = 1'b0; cyc(12);
    stby_n = 1'b0; cyc(15);
    chk("R8 unchanged no flag", mode_viol, 0);
    mode_sel = 3'd2; cyc(3);
    chk("R8 change flagged", mode_viol, 1);
    mode_sel = 3'd5; cyc(3);
    chk("R8 sticky", mode_viol, 1);
    leave_standby_to_run();
  endtask

  initial begin
    por_n = 1'b0; stby_n = 1'b1; res_n = 1'b0; ram_en = 1'b0; mode_sel = 3'd0;
    cyc(3);
    t_por();
    t_bring_up();
    t_warm();
    t_enter_from_run();
    t_exit_wrong();
    t_stab_short();
    t_ret(12, 1'b1, 1);
    t_ret(10, 1'b1, 1);
    t_ret(9, 1'b1, 0);
    t_ret(3, 1'b0, 1);
    t_zero_hold();
    t_mode();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule